// File: doc/BRIEF.md
# Four-Channel Double-Data-Rate Converter Capture

This block sits between the input buffers of a four-channel analog-to-digital converter and a stream consumer such as a DMA writer. The converter drives its own clock and a parallel bus in which every lane carries two bits per clock period: one bit is valid at the rising edge and another at the falling edge. The block puts each channel's 14-bit code back together from those halves. It zero-extends each code to a 16-bit slot and packs the four simultaneous channel values into one 64-bit beat.

Beats are written into a 16-entry asynchronous FIFO in the converter clock domain. They are read out in the system clock domain as an AXI4-Stream master with TVALID, TREADY, TDATA and TLAST. The read and write pointers cross between the two domains in Gray code through two-flop synchronizers. A system-domain enable starts and stops capture. A sticky overflow flag records samples that were dropped because the FIFO was full. TLAST marks the end of every frame of a programmable number of beats.

Top module: `quad_adc_capture`

## Requirements
- R1: Channel c (0..3) owns lanes 7c..7c+6. At a rising converter-clock edge, lane 7c+j carries code bit 2j. At the following falling edge, the same lane carries code bit 2j+1. Those two halves form one sample.
- R2: Channel c's code sits in TDATA bits [16c+13:16c], with bits [16c+15:16c+14] zero, so channel 0 is the least significant halfword.
- R3: The enable is synchronized into the converter domain. Suppose it rises between converter rising edges 0 and 1, and falls between rising edges k and k+1 (k≥3). Then exactly the samples whose even half is taken at rising edges 3..k+1 are delivered. A sample whose even half has been taken when the synchronized enable drops is discarded.
- R4: Beats leave in the order they were captured, with no loss, duplication or spurious beat, and the FIFO holds 16 beats.
- R5: A sample that arrives while the FIFO is full is discarded. The beats already stored are delivered unchanged.
- R6: A dropped sample sets the overflow flag, which stays set until the system-domain clear input is high at a clock edge.
- R7: When a drop and the clear fall on the same system clock edge, the flag is set.
- R8: TLAST is high on every Nth accepted beat, where N is the frame-length input. A frame length of 0 or 1 makes every beat last.
- R9: After reset, TVALID, TLAST (for a frame length above 1) and the overflow flag are low, and the beat count starts at zero.
- R10: While TVALID is high and TREADY is low, TVALID, TDATA and TLAST hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adc_clk | input | 1 | Clock supplied by the converter |
| adc_rst_n | input | 1 | Active-low asynchronous reset, converter domain |
| adc_lanes | input | 28 | Single-ended data lanes, two bits per clock period |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| cap_en | input | 1 | Capture enable (system domain) |
| ovf_clr | input | 1 | Synchronous clear of the overflow flag |
| frame_len | input | 16 | Beats per frame for TLAST |
| m_tdata | output | 64 | Stream data, four 16-bit channel slots |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Last beat of a frame |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
Two system-domain events can land on the same edge: a drop event arriving from the converter domain, and the software clear of the flag. The bench holds the clear input high for the whole of a burst that overruns a stalled FIFO, so that every drop coincides with an active clear. If the set did not take priority, the flag would never rise. The flag must therefore be seen high at least once during the burst, and it must read low once the drops stop while the clear is still held.

// File: rtl/qac_pkg.sv
`timescale 1ns/1ps
package qac_pkg;
    localparam int NCH          = 4;
    localparam int CODE_W       = 14;
    localparam int SLOT_W       = 16;
    localparam int LANES_PER_CH = CODE_W / 2;
    localparam int NLANE        = NCH * LANES_PER_CH;
    localparam int BEAT_W       = NCH * SLOT_W;

    typedef logic [BEAT_W-1:0] beat_t;
    typedef logic [NLANE-1:0]  lanes_t;
endpackage

// File: rtl/qac_sync2.sv
`timescale 1ns/1ps
module qac_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/qac_ddr_capture.sv
`timescale 1ns/1ps
module qac_ddr_capture
    import qac_pkg::*;
(
    input  logic   adc_clk,
    input  logic   adc_rst_n,
    input  lanes_t lanes,
    input  logic   cap_en,
    output logic   push,
    output beat_t  push_data
);
    typedef struct packed {
        logic   en_s1;
        logic   en_s2;
        logic   half_ok;
        lanes_t rise;
    } cap_t;

    cap_t   cap_q, cap_d;
    lanes_t fall_q;

    // Odd bits: taken on the falling edge after the even half.
    always_ff @(negedge adc_clk or negedge adc_rst_n) begin
        if (!adc_rst_n) fall_q <= '0;
        else            fall_q <= lanes;
    end

    always_comb begin
        cap_d         = cap_q;
        cap_d.en_s1   = cap_en;
        cap_d.en_s2   = cap_q.en_s1;
        cap_d.half_ok = cap_q.en_s2;   // even half taken while enabled
        cap_d.rise    = lanes;
    end

    always_ff @(posedge adc_clk or negedge adc_rst_n) begin
        if (!adc_rst_n) cap_q <= '0;
        else            cap_q <= cap_d;
    end

    // Both halves must fall inside the enabled window.
    assign push = cap_q.half_ok & cap_q.en_s2;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar j = 0; j < LANES_PER_CH; j++) begin : g_bit
            assign push_data[c*SLOT_W + 2*j]     = cap_q.rise[c*LANES_PER_CH + j];
            assign push_data[c*SLOT_W + 2*j + 1] = fall_q[c*LANES_PER_CH + j];
        end
        if (SLOT_W > CODE_W) begin : g_pad
            assign push_data[c*SLOT_W + CODE_W +: SLOT_W - CODE_W] = '0;
        end
    end
endmodule

// File: rtl/qac_async_fifo.sv
`timescale 1ns/1ps
module qac_async_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    output logic          drop_tgl,
    output logic [PW-1:0] wr_ptr,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          drop;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rside_t;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    wside_t w_q, w_d;
    rside_t r_q, r_d;
    logic [PW-1:0] rgray_ws, wgray_rs;
    logic [DW-1:0] mem [DEPTH];

    qac_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(r_q.gray), .q(rgray_ws));
    qac_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(w_q.gray), .q(wgray_rs));

    assign wr_full  = (w_q.gray == {~rgray_ws[AW:AW-1], rgray_ws[AW-2:0]});
    assign drop_tgl = w_q.drop;
    assign wr_ptr   = w_q.bin;

    always_comb begin
        w_d = w_q;
        if (wr_en) begin
            if (wr_full) begin
                w_d.drop = ~w_q.drop;
            end else begin
                w_d.bin  = w_q.bin + 1'b1;
                w_d.gray = to_gray(w_d.bin);
            end
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (wr_en && !wr_full) mem[w_q.bin[AW-1:0]] <= wr_data;
    end

    assign rd_empty = (r_q.gray == wgray_rs);
    assign rd_data  = mem[r_q.bin[AW-1:0]];

    always_comb begin
        r_d = r_q;
        if (rd_pop && !rd_empty) begin
            r_d.bin  = r_q.bin + 1'b1;
            r_d.gray = to_gray(r_d.bin);
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) r_q <= '0;
        else         r_q <= r_d;
    end
endmodule

// File: rtl/qac_stream_out.sv
`timescale 1ns/1ps
module qac_stream_out #(
    parameter int DW = 64,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_empty,
    input  logic [DW-1:0] rd_data,
    output logic          rd_pop,
    input  logic          drop_tgl_s,
    output logic          drop_evt,
    input  logic          ovf_clr,
    input  logic [FW-1:0] frame_len,
    output logic [DW-1:0] m_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic          m_tlast,
    output logic          ovf_flag
);
    typedef struct packed {
        logic [FW-1:0] beat_cnt;
        logic          ovf;
        logic          tgl_seen;
    } out_t;

    out_t o_q, o_d;
    logic [FW-1:0] last_idx;

    assign last_idx = (frame_len == '0) ? '0 : frame_len - 1'b1;
    assign m_tvalid = ~rd_empty;
    assign m_tdata  = rd_data;
    assign m_tlast  = (o_q.beat_cnt >= last_idx);
    assign rd_pop   = m_tvalid & m_tready;
    assign drop_evt = drop_tgl_s ^ o_q.tgl_seen;
    assign ovf_flag = o_q.ovf;

    always_comb begin
        o_d          = o_q;
        o_d.tgl_seen = drop_tgl_s;
        if (rd_pop) o_d.beat_cnt = m_tlast ? '0 : o_q.beat_cnt + 1'b1;
        if (drop_evt)     o_d.ovf = 1'b1;   // a drop outranks the clear
        else if (ovf_clr) o_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end
endmodule

// File: rtl/quad_adc_capture.sv
`timescale 1ns/1ps
module quad_adc_capture
    import qac_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int FRAME_W = 16
) (
    input  logic               adc_clk,
    input  logic               adc_rst_n,
    input  logic [NLANE-1:0]   adc_lanes,
    input  logic               sys_clk,
    input  logic               sys_rst_n,
    input  logic               cap_en,
    input  logic               ovf_clr,
    input  logic [FRAME_W-1:0] frame_len,
    output logic [BEAT_W-1:0]  m_tdata,
    output logic               m_tvalid,
    input  logic               m_tready,
    output logic               m_tlast,
    output logic               ovf_flag
);
    localparam int PTR_W = $clog2(DEPTH) + 1;

    logic             cap_push;
    beat_t            cap_data;
    logic             fifo_full;
    logic             drop_tgl;
    logic             drop_tgl_s;
    logic             drop_evt;
    logic [PTR_W-1:0] wr_ptr;
    logic             fifo_empty;
    beat_t            fifo_data;
    logic             fifo_pop;

    qac_ddr_capture u_cap (
        .adc_clk   (adc_clk),
        .adc_rst_n (adc_rst_n),
        .lanes     (adc_lanes),
        .cap_en    (cap_en),
        .push      (cap_push),
        .push_data (cap_data)
    );

    qac_async_fifo #(.DW(BEAT_W), .DEPTH(DEPTH)) u_fifo (
        .wclk     (adc_clk),
        .wrst_n   (adc_rst_n),
        .wr_en    (cap_push),
        .wr_data  (cap_data),
        .wr_full  (fifo_full),
        .drop_tgl (drop_tgl),
        .wr_ptr   (wr_ptr),
        .rclk     (sys_clk),
        .rrst_n   (sys_rst_n),
        .rd_pop   (fifo_pop),
        .rd_data  (fifo_data),
        .rd_empty (fifo_empty)
    );

    qac_sync2 #(.W(1)) u_drop_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (drop_tgl),
        .q     (drop_tgl_s)
    );

    qac_stream_out #(.DW(BEAT_W), .FW(FRAME_W)) u_out (
        .clk        (sys_clk),
        .rst_n      (sys_rst_n),
        .rd_empty   (fifo_empty),
        .rd_data    (fifo_data),
        .rd_pop     (fifo_pop),
        .drop_tgl_s (drop_tgl_s),
        .drop_evt   (drop_evt),
        .ovf_clr    (ovf_clr),
        .frame_len  (frame_len),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tlast    (m_tlast),
        .ovf_flag   (ovf_flag)
    );
endmodule

// File: rtl/qac_checker.sv
`timescale 1ns/1ps
module qac_checker #(
    parameter int FW = 16,
    parameter int PW = 5
) (
    input logic          sys_clk,
    input logic          sys_rst_n,
    input logic          adc_clk,
    input logic          adc_rst_n,
    input logic [63:0]   m_tdata,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic          m_tlast,
    input logic          ovf_flag,
    input logic          ovf_clr,
    input logic [FW-1:0] frame_len,
    input logic          drop_evt,
    input logic          cap_push,
    input logic          fifo_full,
    input logic [PW-1:0] wr_ptr
);
    p_stall_hold_r10: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    p_zero_pad_r2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        m_tvalid |-> (m_tdata[15:14] == 2'b00 && m_tdata[31:30] == 2'b00 &&
                      m_tdata[47:46] == 2'b00 && m_tdata[63:62] == 2'b00));

    p_ovf_sticky_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag);

    p_ovf_clear_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ovf_clr && !drop_evt |=> !ovf_flag);

    p_set_wins_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        drop_evt |=> ovf_flag);

    p_every_beat_last_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        m_tvalid && frame_len <= 1 |-> m_tlast);

    p_no_overflow_r5: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
        cap_push && fifo_full |=> $stable(wr_ptr));
endmodule

bind quad_adc_capture qac_checker #(.FW(FRAME_W), .PW(PTR_W)) u_chk (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .adc_clk   (adc_clk),
    .adc_rst_n (adc_rst_n),
    .m_tdata   (m_tdata),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready),
    .m_tlast   (m_tlast),
    .ovf_flag  (ovf_flag),
    .ovf_clr   (ovf_clr),
    .frame_len (frame_len),
    .drop_evt  (drop_evt),
    .cap_push  (cap_push),
    .fifo_full (fifo_full),
    .wr_ptr    (wr_ptr)
);

// File: tb/quad_adc_capture_tb.sv
`timescale 1ns/1ps
module quad_adc_capture_tb;
    import qac_pkg::*;

    logic          sys_clk = 1'b0;
    logic          adc_clk = 1'b0;
    logic          sys_rst_n, adc_rst_n;
    logic [27:0]   adc_lanes;
    logic          cap_en, ovf_clr, m_tready;
    logic [15:0]   frame_len;
    logic [63:0]   m_tdata;
    logic          m_tvalid, m_tlast, ovf_flag;

    always #2.5 sys_clk = ~sys_clk;   // 200 MHz
    always #100 adc_clk = ~adc_clk;   // 5 MHz converter clock

    quad_adc_capture u_dut (
        .adc_clk(adc_clk), .adc_rst_n(adc_rst_n), .adc_lanes(adc_lanes),
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cap_en(cap_en),
        .ovf_clr(ovf_clr), .frame_len(frame_len), .m_tdata(m_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .ovf_flag(ovf_flag)
    );

    int          checks = 0;
    int          errors = 0;
    int          pat_mode = 0;
    int          bcnt = 0;
    int          beats_seen = 0;
    logic        ovf_seen = 1'b0;
    logic        stall_prev = 1'b0;
    logic [63:0] stall_data;
    logic [63:0] exp_q[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] code(input int i, input int c);
        if (pat_mode == 1) return (i % 2 == 1) ? 14'h3FFF : 14'h2AAA ^ 14'(c);
        return 14'((i * 32'h1357 + c * 32'h0A5B + 32'h0111) & 32'h3FFF);
    endfunction

    function automatic logic [63:0] build(input int i);
        logic [63:0] b = '0;
        for (int c = 0; c < 4; c++) b[c*16 +: 16] = {2'b00, code(i, c)};
        return b;
    endfunction

    function automatic logic [27:0] half_lanes(input int i, input int odd);
        logic [27:0] l = '0;
        for (int c = 0; c < 4; c++) begin
            logic [13:0] v = code(i, c);
            for (int j = 0; j < 7; j++) l[c*7 + j] = v[2*j + odd];
        end
        return l;
    endfunction

    // Driver: enable just after rising edge 0, disable just after rising edge k.
    // Samples with even half at rising edges 3..k+1 are expected (R3).
    task automatic burst(input int k, input int room);
        @(posedge adc_clk);
        #20 cap_en = 1'b1;
        for (int i = 1; i <= k + 4; i++) begin
            @(negedge adc_clk);
            #50 adc_lanes = half_lanes(i, 0);
            @(posedge adc_clk);
            #20;
            if (i == k) cap_en = 1'b0;
            if (i >= 3 && i <= k + 1 && (room < 0 || exp_q.size() < room))
                exp_q.push_back(build(i));
            #30 adc_lanes = half_lanes(i, 1);
        end
    endtask

    task automatic do_reset();
        sys_rst_n = 1'b0; adc_rst_n = 1'b0;
        cap_en = 1'b0; ovf_clr = 1'b0; m_tready = 1'b1; adc_lanes = '0;
        repeat (3) @(posedge adc_clk);
        #20 sys_rst_n = 1'b1; adc_rst_n = 1'b1;
        bcnt = 0;
        exp_q.delete();
    endtask

    task automatic drain();
        @(posedge sys_clk); #1 m_tready = 1'b1;
        repeat (300) @(posedge sys_clk);
    endtask

    // Monitor / scoreboard
    always @(negedge sys_clk) begin
        if (sys_rst_n) begin
            if (ovf_flag) ovf_seen = 1'b1;
            if (m_tvalid && !m_tready) begin
                if (stall_prev) check(m_tdata == stall_data, "R10 stalled data", m_tdata, stall_data);
                stall_prev = 1'b1;
                stall_data = m_tdata;
            end else begin
                stall_prev = 1'b0;
            end
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected beat", m_tdata, 64'h0);
                end else begin
                    logic [63:0] e;
                    int lim;
                    e = exp_q.pop_front();
                    check(m_tdata == e, "R1 R2 R4 beat data", m_tdata, e);
                    lim = (frame_len == 0) ? 0 : int'(frame_len) - 1;
                    check(m_tlast == (bcnt >= lim), "R8 tlast", 64'(m_tlast), 64'(bcnt >= lim));
                    bcnt = (bcnt >= lim) ? 0 : bcnt + 1;
                    beats_seen++;
                end
            end
        end else begin
            stall_prev = 1'b0;
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int start;
        frame_len = 16'd4;
        do_reset();
        @(negedge sys_clk);
        check(m_tvalid == 1'b0, "R9 tvalid after reset", 64'(m_tvalid), 64'h0);
        check(ovf_flag == 1'b0, "R9 overflow after reset", 64'(ovf_flag), 64'h0);
        check(m_tlast == 1'b0, "R9 tlast after reset", 64'(m_tlast), 64'h0);

        // Plain burst, consumer always ready
        start = beats_seen;
        burst(6, -1);
        drain();
        check(beats_seen - start == 5, "R3 enable window count", 64'(beats_seen - start), 64'd5);
        check(exp_q.size() == 0, "R4 all beats delivered", 64'(exp_q.size()), 64'h0);

        // Burst with an intermittent consumer
        fork
            burst(9, -1);
            for (int n = 0; n < 2600; n++) begin
                @(posedge sys_clk); #1 m_tready = (n % 5) < 2;
            end
        join
        drain();
        check(exp_q.size() == 0, "R10 R4 intermittent ready", 64'(exp_q.size()), 64'h0);
        check(ovf_flag == 1'b0, "R6 no overflow yet", 64'(ovf_flag), 64'h0);

        // Overflow: stalled consumer, 20 samples into 16 entries
        @(posedge sys_clk); #1 m_tready = 1'b0;
        burst(21, 16);
        repeat (40) @(posedge sys_clk);
        @(negedge sys_clk);
        check(ovf_flag == 1'b1, "R6 overflow set", 64'(ovf_flag), 64'h1);
        check(m_tvalid == 1'b1, "R4 data held while full", 64'(m_tvalid), 64'h1);
        repeat (200) @(posedge sys_clk);
        @(negedge sys_clk);
        check(ovf_flag == 1'b1, "R6 overflow sticky", 64'(ovf_flag), 64'h1);
        start = beats_seen;
        drain();
        check(beats_seen - start == 16, "R5 only stored beats delivered", 64'(beats_seen - start), 64'd16);
        check(exp_q.size() == 0, "R5 queue drained", 64'(exp_q.size()), 64'h0);
        @(posedge sys_clk); #1 ovf_clr = 1'b1;
        @(posedge sys_clk); #1 ovf_clr = 1'b0;
        @(negedge sys_clk);
        check(ovf_flag == 1'b0, "R6 overflow cleared", 64'(ovf_flag), 64'h0);

        // Clear held high while drops occur: set must win (R7)
        @(posedge sys_clk); #1 begin ovf_clr = 1'b1; m_tready = 1'b0; end
        ovf_seen = 1'b0;
        burst(21, 16);
        repeat (60) @(posedge sys_clk);
        @(negedge sys_clk);
        check(ovf_seen == 1'b1, "R7 set wins over clear", 64'(ovf_seen), 64'h1);
        check(ovf_flag == 1'b0, "R6 clear after drops stop", 64'(ovf_flag), 64'h0);
        @(posedge sys_clk); #1 ovf_clr = 1'b0;
        drain();
        check(exp_q.size() == 0, "R5 queue drained again", 64'(exp_q.size()), 64'h0);

        // Frame length 0: every beat last; extreme codes for padding
        frame_len = 16'd0;
        pat_mode = 1;
        do_reset();
        @(negedge sys_clk);
        check(m_tvalid == 1'b0, "R9 tvalid after second reset", 64'(m_tvalid), 64'h0);
        start = beats_seen;
        burst(7, -1);
        drain();
        check(beats_seen - start == 6, "R3 R8 second window count", 64'(beats_seen - start), 64'd6);

        frame_len = 16'd1;
        burst(4, -1);
        drain();
        check(exp_q.size() == 0, "R8 frame length one", 64'(exp_q.size()), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule